// File: doc/BRIEF.md
# DAC Channel Power and Reference Manager

This block keeps the power state of eight analog output channels and of an on-chip voltage reference. It takes decoded commands from the register controller, per-channel update strobes and the level of the asynchronous load pin, already synchronized to the clock. From these it produces a power-down flag per channel, which tells the analog side to float the output and pull it down. It also drives a reference-select flag, a reference-enabled flag and an enable for the shared bias generator. Register contents are held elsewhere and are not touched by power changes.

When a channel leaves power-down, a per-channel "settling" flag is raised for a fixed number of timing ticks. The count is the short delay when some part of the chip was still powered. It is the long delay when every channel and the reference were off, because the bias generator must restart as well. How the reference comes back depends on how it was turned off. After a chip-wide power-down, any channel wake-up restores it. After an explicit switch to the external reference, only a command that selects the internal reference restores it.

Top module: `dac_pwr_mgr`

## Requirements
- R1: After reset every channel is powered, no settling flag is set, and the bias generator is on. Reference select and reference enable both equal the `REF_INT_DEFAULT` parameter.
- R2: A valid command with code 4'b0100 powers down only the channel whose number equals the 4-bit address. Address 4'hF powers down all channels, and an address of 8 to 14 changes nothing. Codes other than 4'b0100, 4'b0101, 4'b0110 and 4'b0111 change no state. Every change is visible one clock after the command.
- R3: Code 4'b0101 powers down every channel and the reference and leaves the reference selection unchanged.
- R4: Code 4'b0110 sets reference select to internal (1) and enables the reference. Code 4'b0111 sets it to external (0) and disables the reference.
- R5: A high update bit for a channel powers that channel up one clock later.
- R6: While the load pin is low, codes 4'b0100 and 4'b0101 have no effect, and every channel is powered up.
- R7: A reference disabled by code 4'b0111 stays off through any channel power-up. A reference disabled by code 4'b0101 comes back on with the first channel power-up event, including one in the same cycle.
- R8: The bias enable is low exactly when all channels are powered down and the reference is off.
- R9: A channel woken from power-down shows its settling flag from the next clock for `DLY_SHORT` tick cycles, or for `DLY_LONG` if the bias generator was off when it woke. A channel that was already powered gets no settling flag.
- R10: Powering a channel down clears its settling flag on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timing-base strobe for settling counters |
| cmd_vld | input | 1 | Decoded command valid for one cycle |
| cmd_code | input | 4 | Command code |
| cmd_addr | input | 4 | Channel address, 4'hF for all channels |
| upd | input | NCH | Per-channel update strobes |
| ldac_n | input | 1 | Synchronized load-pin level, active low |
| ch_pd | output | NCH | Channel powered down (output floated with pull-down) |
| ref_int_sel | output | 1 | 1 selects the internal reference |
| ref_on | output | 1 | Internal reference enabled |
| bias_on | output | 1 | Shared bias generator enabled |
| settling | output | NCH | Channel is inside its power-up delay |

## Verification
Directed sequences cover single-channel, broadcast and reserved-address power-down, then a wake from the fully-off state. That wake must give the long delay and restore the reference. A second wake after an external-reference switch must give the long delay but leave the reference off. A later wake must give the short delay, so the two delay choices are told apart by the counted flag length. The load pin is driven low together with a power-down command to show that the command is masked. Random commands, addresses, strobes, load-pin pulses and sparse ticks then run against a bench model. These expose ordering faults between power-down, wake-up and the reference rules.

// File: rtl/dac_pwr_mgr.sv
module dac_pwr_mgr #(
  parameter int NCH = 8,
  parameter int DLY_SHORT = 1250,
  parameter int DLY_LONG = 1500,
  parameter bit REF_INT_DEFAULT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           cmd_vld,
  input  logic [3:0]     cmd_code,
  input  logic [3:0]     cmd_addr,
  input  logic [NCH-1:0] upd,
  input  logic           ldac_n,
  output logic [NCH-1:0] ch_pd,
  output logic           ref_int_sel,
  output logic           ref_on,
  output logic           bias_on,
  output logic [NCH-1:0] settling
);
  localparam int CW = $clog2(DLY_LONG + 1);
  localparam logic [3:0] C_PD_CH = 4'b0100, C_PD_CHIP = 4'b0101;
  localparam logic [3:0] C_REF_INT = 4'b0110, C_REF_EXT = 4'b0111;
  localparam logic [3:0] A_ALL = 4'hF;

  logic ref_chip_off;
  logic [NCH-1:0] pd_mask, pu, wake;

  wire pd_ok   = cmd_vld & ldac_n;
  wire pd_one  = pd_ok & (cmd_code == C_PD_CH);
  wire pd_chip = pd_ok & (cmd_code == C_PD_CHIP);
  wire sel_int = cmd_vld & (cmd_code == C_REF_INT);
  wire sel_ext = cmd_vld & (cmd_code == C_REF_EXT);

  assign pu      = upd | {NCH{~ldac_n}};
  assign wake    = pu & ch_pd;
  assign bias_on = ~((&ch_pd) & ~ref_on);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ch_pd <= '0;
    else        ch_pd <= (ch_pd | pd_mask) & ~pu;

  logic on_a, off_a;
  always_comb begin
    on_a  = pd_chip ? 1'b0 : ref_on;
    off_a = pd_chip ? (ref_chip_off | ref_on) : ref_chip_off;
    if ((|pu) && off_a) begin
      on_a  = 1'b1;
      off_a = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_int_sel  <= REF_INT_DEFAULT;
      ref_on       <= REF_INT_DEFAULT;
      ref_chip_off <= 1'b0;
    end else if (sel_int) begin
      ref_int_sel  <= 1'b1;
      ref_on       <= 1'b1;
      ref_chip_off <= 1'b0;
    end else if (sel_ext) begin
      ref_int_sel  <= 1'b0;
      ref_on       <= 1'b0;
      ref_chip_off <= 1'b0;
    end else begin
      ref_on       <= on_a;
      ref_chip_off <= off_a;
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cnt;
    assign pd_mask[i] = pd_chip | (pd_one & ((cmd_addr == A_ALL) || (cmd_addr == 4'(i))));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     cnt <= '0;
      else if (pd_mask[i] && !pu[i])  cnt <= '0;
      else if (wake[i])               cnt <= bias_on ? CW'(DLY_SHORT) : CW'(DLY_LONG);
      else if (tick && cnt != '0)     cnt <= cnt - 1'b1;
    assign settling[i] = (cnt != '0);

    p_wake_settles_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake[i] |=> settling[i]);
  end

  p_load_low_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ldac_n |=> (ch_pd == '0));
  p_chip_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_code == C_PD_CHIP && ldac_n && upd == '0) |=> (&ch_pd) && !ref_on && !bias_on);
  p_sel_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_code == C_REF_INT) |=> ref_int_sel && ref_on);
  p_ext_stays_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_int_sel |-> !ref_on);
  p_no_settle_when_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (settling & ch_pd) == '0);
  p_bias_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bias_on) && !bias_on) |-> (&ch_pd));
endmodule

// File: tb/dac_pwr_mgr_tb.sv
module dac_pwr_mgr_tb;
  localparam int NCH = 8, DS = 10, DL = 12;
  logic clk = 0, rst_n = 0, tick = 0, cmd_vld = 0, ldac_n = 1;
  logic [3:0] cmd_code = 0, cmd_addr = 0;
  logic [NCH-1:0] upd = 0, ch_pd, settling;
  logic ref_int_sel, ref_on, bias_on;
  int n_chk = 0, n_fail = 0;

  dac_pwr_mgr #(.NCH(NCH), .DLY_SHORT(DS), .DLY_LONG(DL), .REF_INT_DEFAULT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .upd(upd), .ldac_n(ldac_n), .ch_pd(ch_pd),
    .ref_int_sel(ref_int_sel), .ref_on(ref_on), .bias_on(bias_on), .settling(settling));

  always #4 clk = ~clk;

  logic [NCH-1:0] m_pd = 0;
  logic m_sel = 1, m_on = 1, m_coff = 0;
  int m_cnt [NCH];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] m_settle();
    for (int i = 0; i < NCH; i++) m_settle[i] = (m_cnt[i] != 0);
  endfunction

  task automatic model(input logic v, input logic [3:0] c, a, input logic [NCH-1:0] u,
                       input logic ld, tk);
    logic bias, chip, any_pu, on, co;
    logic [NCH-1:0] npd;
    bias = !((&m_pd) && !m_on);
    chip = v && ld && c == 4'b0101;
    any_pu = (|u) || !ld;
    for (int i = 0; i < NCH; i++) begin
      logic pdm, pui;
      pdm = chip || (v && ld && c == 4'b0100 && (a == 4'hF || a == 4'(i)));
      pui = u[i] || !ld;
      if (pdm && !pui) m_cnt[i] = 0;
      else if (pui && m_pd[i]) m_cnt[i] = bias ? DS : DL;
      else if (tk && m_cnt[i] > 0) m_cnt[i]--;
      npd[i] = (m_pd[i] || pdm) && !pui;
    end
    m_pd = npd;
    on = m_on; co = m_coff;
    if (chip) begin co = co | on; on = 0; end
    if (any_pu && co) begin on = 1; co = 0; end
    if (v && c == 4'b0110) begin m_sel = 1; on = 1; co = 0; end
    if (v && c == 4'b0111) begin m_sel = 0; on = 0; co = 0; end
    m_on = on; m_coff = co;
  endtask

  task automatic step(input logic v, input logic [3:0] c, a, input logic [NCH-1:0] u,
                      input logic ld, tk);
    @(negedge clk);
    cmd_vld = v; cmd_code = c; cmd_addr = a; upd = u; ldac_n = ld; tick = tk;
    model(v, c, a, u, ld, tk);
    @(posedge clk); #2;
    chk(ch_pd == m_pd, "R2/R5/R6 ch_pd", ch_pd, m_pd);
    chk(settling == m_settle(), "R9/R10 settling", settling, m_settle());
    chk({ref_int_sel, ref_on} == {m_sel, m_on}, "R4/R7 ref", {ref_int_sel, ref_on}, {m_sel, m_on});
    chk(bias_on == !((&m_pd) && !m_on), "R8 bias", bias_on, !((&m_pd) && !m_on));
  endtask

  task automatic idle(input logic tk); step(0, 4'hF, 0, 0, 1, tk); endtask

  task automatic measure(input int ch, input int exp, input string tag);
    int len = 0;
    while (settling[ch] && len < 100) begin len++; idle(1); end
    chk(len == exp, tag, len, exp);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(ch_pd == 0 && settling == 0 && bias_on, "R1 reset channels", {ch_pd, settling}, 0);
    chk(ref_int_sel && ref_on, "R1 reset ref", {ref_int_sel, ref_on}, 3);

    step(1, 4'b0100, 4'd3, 0, 1, 1);
    chk(ch_pd == 8'h08, "R2 single channel down", ch_pd, 8'h08);
    step(1, 4'b0100, 4'd9, 0, 1, 1);
    chk(ch_pd == 8'h08, "R2 reserved address", ch_pd, 8'h08);
    step(1, 4'b1000, 4'hF, 0, 1, 1);
    chk(ch_pd == 8'h08, "R2 reserved code", ch_pd, 8'h08);
    step(1, 4'b0101, 4'd0, 0, 1, 1);
    chk(ch_pd == 8'hFF && !ref_on && ref_int_sel, "R3 chip down", {ch_pd, ref_on}, 9'h1FE);
    chk(!bias_on, "R8 bias off", bias_on, 0);
    step(0, 4'hF, 0, 8'h01, 1, 1);
    chk(ch_pd == 8'hFE && ref_on, "R5 R7 wake restores ref", {ch_pd, ref_on}, 9'h1FD);
    measure(0, DL, "R9 long delay");

    step(1, 4'b0111, 0, 0, 1, 1);
    chk(!ref_int_sel && !ref_on, "R4 external select", {ref_int_sel, ref_on}, 0);
    step(1, 4'b0100, 4'hF, 0, 1, 1);
    chk(ch_pd == 8'hFF && !bias_on, "R2 R8 broadcast down", {ch_pd, bias_on}, 9'h1FE);
    step(0, 4'hF, 0, 8'h02, 1, 1);
    chk(!ref_on, "R7 external ref stays off", ref_on, 0);
    measure(1, DL, "R9 long delay after external");
    step(0, 4'hF, 0, 8'h24, 1, 1);
    measure(2, DS, "R9 short delay");
    step(0, 4'hF, 0, 8'h02, 1, 1);
    chk(settling[1] == 0, "R9 no settle when powered", settling[1], 0);

    step(0, 4'hF, 0, 8'h20, 1, 1);
    step(1, 4'b0100, 4'd5, 0, 1, 1);
    step(0, 4'hF, 0, 8'h20, 1, 0);
    step(1, 4'b0100, 4'd5, 0, 1, 1);
    chk(ch_pd[5] && !settling[5], "R10 down clears settling", {ch_pd[5], settling[5]}, 2);
    step(1, 4'b0101, 4'd0, 0, 0, 1);
    chk(ch_pd == 0, "R6 masked power-down", ch_pd, 0);

    step(1, 4'b0110, 0, 0, 1, 1);
    chk(ref_int_sel && ref_on, "R4 internal select", {ref_int_sel, ref_on}, 3);

    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic v, ld, tk;
      logic [3:0] c, a;
      logic [NCH-1:0] u;
      int r;
      v = ($urandom % 3) == 0;
      r = $urandom % 10;
      c = (r < 4) ? 4'b0100 : (r < 6) ? 4'b0101 : (r == 6) ? 4'b0110 :
          (r == 7) ? 4'b0111 : 4'($urandom);
      a = ($urandom % 4 == 0) ? 4'hF : 4'($urandom);
      u = ($urandom % 6 == 0) ? NCH'(1 << ($urandom % NCH)) : '0;
      ld = ($urandom % 25) != 0;
      tk = ($urandom % 2) == 0;
      step(v, c, a, u, ld, tk);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule